// File: doc/BRIEF.md
# Register-Stack RAM with Output Register

A sixteen-word, four-bit memory meant to hold a small stack of operands, with an output register placed behind the array so that a new word can be written while the previous result is still on the outputs. An active-low select and write enable qualify every operation. A strobe input carries the timing. While the strobe is low, the write is level-sensitive: the addressed word follows the data inputs for as long as select, write enable and strobe all stay low. The strobe's rising edge loads the output register. When write enable is high, the register takes the addressed word. When write enable is low, it takes the data inputs directly, and the array is not consulted on that edge.

Inside a larger chip the strobe is sampled on the system clock `clk`. A rising strobe edge is a cycle in which the strobe is high after being low in the cycle before. Writes are taken at every clock edge at which the write condition holds. A parameter selects a second storage model in which the array is a bank of transparent latches opened directly by the write condition. Both models must leave the same contents. The output drivers are represented by a data vector and a separate drive enable taken from the active-low output enable, as a pad ring expects.

Top module: `regstk`

## Requirements
- R1: The array holds 16 independent 4-bit words selected by `addr[3:0]`; writing one word leaves the other fifteen unchanged.
- R2: At a `clk` rising edge where `cs_n`, `we_n` and `stb` are all 0, the word at `addr` takes the value of `din`.
- R3: While the write condition of R2 is held over several cycles at one address, the stored word follows `din` and keeps the last value presented once the write ends.
- R4: A strobe rise (`stb` 1 at a clock edge, 0 at the edge before) with `cs_n`=0 and `we_n`=1 loads the word at `addr` into the output register; `q` shows it one clock after that edge.
- R5: A strobe rise with `cs_n`=0 and `we_n`=0 loads `din` into the output register, and the addressed word keeps the value it held before that edge.
- R6: `q` changes only on a strobe rise with `cs_n`=0 or on reset; writes alone never change it.
- R7: With `cs_n`=1, neither the array nor the output register changes, whatever `stb` and `we_n` do.
- R8: `q_en` equals the inverse of `oe_n` in the same cycle (1 = outputs driven, 0 = high impedance); `oe_n` has no effect on `q` or on the array.
- R9: `rst_n` is a synchronous active-low reset that clears the output register to 0 and leaves the array contents untouched.
- R10: The latch-based storage model (`WR_MODEL` = `WR_LATCHED`) ends every sequence with the same stored words and the same `q` as the sampled model.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all registers and strobe sampling |
| rst_n | input | 1 | Synchronous active-low reset of the output register |
| addr | input | AW (4) | Word address |
| din | input | DW (4) | Write data, also the register source on a write-edge |
| cs_n | input | 1 | Active-low select |
| we_n | input | 1 | Active-low write enable |
| stb | input | 1 | Strobe: writes while low, register load on its rise |
| oe_n | input | 1 | Active-low output enable |
| q | output | DW (4) | Output register contents |
| q_en | output | 1 | Output driver enable (1 = drive, 0 = high impedance) |

## Verification
A corrupted array word stays hidden until that address is read back. It then appears on `q` exactly one clock after the read strobe's rise, so the bench reads back every address it has touched and compares each one. A wrong edge decision has a shorter path. A missed or spurious capture, or a capture from the wrong source on a write-edge, shows on `q` one clock after the strobe edge in question. Checks placed right after each edge and during write-only stretches catch it there. A difference between the two storage models shows on the first read that follows the write that exposes it.

// File: rtl/regstk_pkg.sv
// Shared types for the register-stack RAM.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package regstk_pkg;

    // Storage model choice for the array.
    typedef enum logic {
        WR_SAMPLED = 1'b0,  // array written at clock edges
        WR_LATCHED = 1'b1   // array is transparent latches
    } wr_model_e;

    // Decoded per-cycle operation from the control inputs.
    typedef struct packed {
        logic wr;      // write condition holds this cycle
        logic cap_rd;  // strobe rise, register takes array word
        logic cap_wr;  // strobe rise, register takes din
    } regstk_cmd_t;

endpackage

// File: rtl/regstk_ctrl.sv
// Control decode: turns select, write enable and the strobe into a write
// level and two capture pulses. The strobe is sampled on clk; a rise is a
// cycle with stb high whose previous sampled value was low.
// Assumes: stb is synchronous to clk and changes at most once per cycle.
module regstk_ctrl
    import regstk_pkg::*;
(
    input  logic        clk,
    input  logic        cs_n,
    input  logic        we_n,
    input  logic        stb,
    output regstk_cmd_t cmd
);

    logic stb_q;
    logic stb_rise;

    // Hold last cycle's strobe level for edge detection (no reset needed:
    // it only mirrors an input one cycle late).
    always_ff @(posedge clk) begin
        stb_q <= stb;
    end

    // Decode the operation for the current cycle.
    always_comb begin
        stb_rise   = stb & ~stb_q;
        cmd.wr     = ~cs_n & ~we_n & ~stb;
        cmd.cap_rd = stb_rise & ~cs_n &  we_n;
        cmd.cap_wr = stb_rise & ~cs_n & ~we_n;
    end

endmodule

// File: rtl/regstk_array.sv
// Storage array of DEPTH words of DW bits with one combinational read port
// and one write port. WR_MODEL picks edge-sampled flops or transparent
// latches; both follow din while wr is held.
// Assumes: wr is low whenever the strobe is high, so no read capture sees
// a word being written in the same cycle.
module regstk_array
    import regstk_pkg::*;
#(
    parameter int        AW       = 4,
    parameter int        DW       = 4,
    parameter wr_model_e WR_MODEL = WR_SAMPLED,
    localparam int       DEPTH    = 1 << AW
) (
    input  logic          clk,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] rd_data
);

    generate
        if (WR_MODEL == WR_LATCHED) begin : g_latch
            logic          unused_clk;
            logic [DW-1:0] mem [DEPTH];

            assign unused_clk = clk;

            // Open the addressed word while the write condition holds.
            always_latch begin
                if (wr) begin
                    mem[addr] <= din;
                end
            end

            // Read the addressed word.
            assign rd_data = mem[addr];
        end else begin : g_flop
            logic [DW-1:0] mem [DEPTH];

            // Take din into the addressed word at each edge with wr high.
            always_ff @(posedge clk) begin
                if (wr) begin
                    mem[addr] <= din;
                end
            end

            // Read the addressed word.
            assign rd_data = mem[addr];
        end
    endgenerate

endmodule

// File: rtl/regstk_outreg.sv
// Output register and driver enable. Loads din on a write-edge, the array
// word on a read-edge, and otherwise holds. The driver enable is the
// inverse of oe_n and never feeds back into the register.
// Assumes: cap_rd and cap_wr are never high together.
module regstk_outreg
    import regstk_pkg::*;
#(
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  regstk_cmd_t   cmd,
    input  logic [DW-1:0] rd_data,
    input  logic [DW-1:0] din,
    input  logic          oe_n,
    output logic [DW-1:0] q,
    output logic          q_en
);

    logic unused_wr;
    assign unused_wr = cmd.wr;

    // Capture the selected source on a strobe rise; synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (cmd.cap_wr) begin
            q <= din;
        end else if (cmd.cap_rd) begin
            q <= rd_data;
        end
    end

    // Drive enable for the output pads.
    always_comb begin
        q_en = ~oe_n;
    end

endmodule

// File: rtl/regstk.sv
// Register-stack RAM top: control decode, storage array and output
// register. See doc/BRIEF.md for the operation rules.
// Assumes: all inputs are synchronous to clk.
module regstk
    import regstk_pkg::*;
#(
    parameter int        AW       = 4,
    parameter int        DW       = 4,
    parameter wr_model_e WR_MODEL = WR_SAMPLED
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    input  logic          cs_n,
    input  logic          we_n,
    input  logic          stb,
    input  logic          oe_n,
    output logic [DW-1:0] q,
    output logic          q_en
);

    regstk_cmd_t   cmd;
    logic [DW-1:0] rd_word;

    regstk_ctrl u_ctrl (
        .clk  (clk),
        .cs_n (cs_n),
        .we_n (we_n),
        .stb  (stb),
        .cmd  (cmd)
    );

    regstk_array #(
        .AW       (AW),
        .DW       (DW),
        .WR_MODEL (WR_MODEL)
    ) u_array (
        .clk     (clk),
        .wr      (cmd.wr),
        .addr    (addr),
        .din     (din),
        .rd_data (rd_word)
    );

    regstk_outreg #(
        .DW (DW)
    ) u_outreg (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd     (cmd),
        .rd_data (rd_word),
        .din     (din),
        .oe_n    (oe_n),
        .q       (q),
        .q_en    (q_en)
    );

endmodule

// File: rtl/regstk_chk.sv
// Checker bound to regstk: relates the ports and the array read word over
// time. Strobe edges are recomputed here from the input itself.
// Assumes: inputs change away from the rising clk edge.
module regstk_chk #(
    parameter int AW = 4,
    parameter int DW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] addr,
    input logic [DW-1:0] din,
    input logic          cs_n,
    input logic          we_n,
    input logic          stb,
    input logic [DW-1:0] rd_word,
    input logic [DW-1:0] q
);

    logic wr_now;
    assign wr_now = !cs_n && !we_n && !stb;

    // R9: a reset cycle leaves the register at zero.
    assert_reset_clear_R9: assert property (@(posedge clk)
        !rst_n |=> q == '0);

    // R4: a read-edge loads the addressed word.
    assert_read_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && !$past(stb) && !cs_n && we_n) |=> q == $past(rd_word));

    // R5: a write-edge loads the data inputs.
    assert_write_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && !$past(stb) && !cs_n && !we_n) |=> q == $past(din));

    // R6: without a selected strobe rise the register holds.
    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(stb && !$past(stb) && !cs_n) |=> $stable(q));

    // R3: when a write ends, the word keeps the last value presented.
    assert_last_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_now) && !wr_now && addr == $past(addr)) |-> rd_word == $past(din));

    // R7: with select inactive the addressed word does not move.
    assert_deselect_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cs_n) && cs_n && addr == $past(addr)) |-> $stable(rd_word));

endmodule

bind regstk regstk_chk #(
    .AW (AW),
    .DW (DW)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .din     (din),
    .cs_n    (cs_n),
    .we_n    (we_n),
    .stb     (stb),
    .rd_word (rd_word),
    .q       (q)
);

// File: tb/regstk_tb.sv
// Directed bench: drives both storage models with the same stimulus and
// compares each against a model kept from the requirements.
module regstk_tb;
    import regstk_pkg::*;

    localparam int AW    = 4;
    localparam int DW    = 4;
    localparam int DEPTH = 1 << AW;

    logic          clk   = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr  = '0;
    logic [DW-1:0] din   = '0;
    logic          cs_n  = 1'b1;
    logic          we_n  = 1'b1;
    logic          stb   = 1'b0;
    logic          oe_n  = 1'b0;
    logic [DW-1:0] q, q_l;
    logic          q_en, q_en_l;

    int            n_chk = 0;
    int            n_bad = 0;
    logic [DW-1:0] exp_mem [DEPTH];
    logic [DW-1:0] exp_q   = '0;

    always #10 clk = ~clk;

    regstk #(.AW(AW), .DW(DW), .WR_MODEL(WR_SAMPLED)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .cs_n(cs_n),
        .we_n(we_n), .stb(stb), .oe_n(oe_n), .q(q), .q_en(q_en)
    );

    regstk #(.AW(AW), .DW(DW), .WR_MODEL(WR_LATCHED)) u_dut_lat (
        .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .cs_n(cs_n),
        .we_n(we_n), .stb(stb), .oe_n(oe_n), .q(q_l), .q_en(q_en_l)
    );

    task automatic check(input string tag, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_q(input string tag);
        check({tag, " (sampled)"}, q, exp_q);
        check({tag, " (latched)"}, q_l, exp_q);
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr_word(input logic [AW-1:0] a, input logic [DW-1:0] d);
        cs_n = 1'b0; we_n = 1'b0; stb = 1'b0; addr = a; din = d;
        tick();
        cs_n = 1'b1; we_n = 1'b1;
        exp_mem[a] = d;
        tick();
    endtask

    task automatic rd_word(input logic [AW-1:0] a);
        cs_n = 1'b0; we_n = 1'b1; stb = 1'b0; addr = a;
        tick();
        stb = 1'b1;
        tick();
        exp_q = exp_mem[a];
        cs_n = 1'b1;
    endtask

    // R9: reset clears the register even with read strobes during reset.
    task automatic t_reset();
        rst_n = 1'b0;
        for (int i = 0; i < 4; i++) begin
            cs_n = 1'b0; we_n = 1'b1; stb = i[0];
            tick();
        end
        exp_q = '0;
        check_q("R9 register after reset");
        cs_n = 1'b1; stb = 1'b0;
        rst_n = 1'b1;
        tick();
    endtask

    // R1/R2: fill every word, then overwrite half and read all back.
    task automatic t_fill();
        for (int i = 0; i < DEPTH; i++) wr_word(AW'(i), DW'(i * 7 + 1));
        for (int i = 0; i < DEPTH; i++) begin
            rd_word(AW'(i));
            check_q($sformatf("R1 R2 readback word %0d", i));
        end
        for (int i = 0; i < DEPTH; i += 2) wr_word(AW'(i), ~DW'(i));
        for (int i = 0; i < DEPTH; i++) begin
            rd_word(AW'(i));
            check_q($sformatf("R1 second pattern word %0d", i));
        end
    endtask

    // R3/R6: a held write follows din; q stays put meanwhile.
    task automatic t_follow();
        rd_word(4'd2);
        check_q("R4 read before held write");
        cs_n = 1'b0; we_n = 1'b0; stb = 1'b0; addr = 4'd9; din = 4'h1;
        tick();
        check_q("R6 q during held write 1");
        din = 4'h6;
        tick();
        check_q("R6 q during held write 2");
        din = 4'hC;
        tick();
        check_q("R6 q during held write 3");
        cs_n = 1'b1; we_n = 1'b1;
        exp_mem[9] = 4'hC;
        tick();
        check_q("R6 q after held write");
        rd_word(4'd9);
        check_q("R3 word keeps last value");
    endtask

    // R5: a write-edge loads din; the array word is not taken or changed.
    task automatic t_cap_wr();
        logic [DW-1:0] old;
        old = exp_mem[5];
        cs_n = 1'b0; we_n = 1'b1; stb = 1'b0; addr = 4'd5;
        tick();
        stb = 1'b1; we_n = 1'b0; din = ~old;
        tick();
        exp_q = ~old;
        check_q("R5 register takes din on write-edge");
        cs_n = 1'b1; we_n = 1'b1;
        tick();
        rd_word(4'd5);
        check_q("R5 word unchanged by write-edge");
    endtask

    // R7: deselected write attempts and strobe rises do nothing.
    task automatic t_deselect();
        rd_word(4'd3);
        check_q("R4 read before deselect test");
        cs_n = 1'b1; we_n = 1'b0; stb = 1'b0; addr = 4'd3; din = ~exp_mem[3];
        tick();
        tick();
        stb = 1'b1;
        tick();
        check_q("R7 no write-edge capture when deselected");
        stb = 1'b0; we_n = 1'b1; addr = 4'd4;
        tick();
        stb = 1'b1;
        tick();
        check_q("R7 no read capture when deselected");
        rd_word(4'd3);
        check_q("R7 word unchanged when deselected");
    endtask

    // R8: output enable only gates the drivers.
    task automatic t_oe();
        oe_n = 1'b1;
        #1;
        check("R8 q_en low when disabled (sampled)", DW'(q_en), DW'(1'b0));
        check("R8 q_en low when disabled (latched)", DW'(q_en_l), DW'(1'b0));
        check_q("R8 q unchanged by disable");
        rd_word(4'd6);
        check_q("R8 register loads while disabled");
        oe_n = 1'b0;
        #1;
        check("R8 q_en high when enabled (sampled)", DW'(q_en), DW'(1'b1));
        check("R8 q_en high when enabled (latched)", DW'(q_en_l), DW'(1'b1));
        tick();
        check_q("R8 q unchanged by enable");
        rd_word(4'd6);
        check_q("R8 word unchanged by enable toggles");
    endtask

    // R9: reset leaves the array intact.
    task automatic t_reset_mem();
        rst_n = 1'b0;
        tick();
        tick();
        exp_q = '0;
        check_q("R9 mid-run reset clears register");
        rst_n = 1'b1;
        rd_word(4'd9);
        check_q("R9 array kept through reset");
    endtask

    // R10: both storage models hold identical contents.
    task automatic t_models();
        for (int i = 0; i < DEPTH; i++) begin
            rd_word(AW'(i));
            check($sformatf("R10 models agree word %0d", i), q_l, q);
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        tick();
        t_reset();
        t_fill();
        t_follow();
        t_cap_wr();
        t_deselect();
        t_oe();
        t_reset_mem();
        t_models();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule